// File: doc/BRIEF.md
# UART Register Front End

This block is the bus-facing register shell of a UART. An APB master sees four word locations: a data port, a read-only status word, a read/write control word and a scaler location that always reads zero. Received characters come in over a valid/ready byte stream and wait in a small receive FIFO. Software drains the FIFO by reading the data port. A write to the data port sends the low byte out on a transmit byte stream, provided the transmitter is enabled.

Serial framing, the baud divider, parity, flow control and FIFO debug access belong to neighbouring logic. This shell presents a transmitter that is always idle. It raises a one-cycle interrupt pulse when a character is received or sent and the matching interrupt enable is set.

The APB side completes every transfer in its access phase with no wait states. Decoding uses an 8-bit byte address, so the system interconnect places the block in its own 256-byte window.

Top module: `uart_reg_front`

## Requirements
- R1: Address decode uses the 8-bit `paddr`. The data port answers at byte address 0x00 and also at 0x03, so a byte access to the top byte lane reaches the same port.
- R2: Status at 0x04 is read-only, and writes to it change nothing. Its bits are:
  - bit 0: data ready
  - bit 1: transmit shift register empty, always 1
  - bit 2: transmit FIFO empty, always 1
  - bit 4: overrun, always 0
  - bit 9: transmit FIFO full, always 0
  - bit 10: receive FIFO full
  - all other bits: 0
- R3: Control at 0x08 stores all 32 written bits and reads them back. Bit 0 enables the receiver, bit 1 the transmitter, bit 2 the receive interrupt and bit 3 the transmit interrupt.
- R4: The scaler location 0x0C and every address other than 0x00, 0x03, 0x04 and 0x08 read as zero. Writes to them change no register.
- R5: After reset, control reads 0, the receive FIFO is empty, status reads 0x0000_0006, and `txValid` and `irq` are low.
- R6: A byte offered on `rxValid`/`rxReady` while control bit 0 is clear is consumed and discarded. It is not stored and does not set data ready.
- R7: A byte taken while the receiver is enabled sets data ready. If control bit 2 is set, `irq` is high for exactly the one cycle after the accepting clock edge.
- R8: A read of the data port returns the oldest stored byte in bits 7:0, with zeros above, and removes that byte. Data ready clears when the last byte is removed. A read while the FIFO is empty returns 0 and leaves data ready clear.
- R9: A write to the data port with control bit 1 set drives `txValid` high for one cycle after the access edge, with `txData` equal to `pwdata[7:0]`. With bit 1 clear, the write produces no `txValid`.
- R10: A transmitted write also pulses `irq` for one cycle when control bit 3 is set. It does not pulse `irq` when bit 3 is clear.
- R11: The receive FIFO holds DEPTH bytes (default 16). While it is full, `rxReady` is low, status bit 10 is 1, and offered bytes are not taken.
- R12: `pready` is always 1 and `pslverr` is always 0. A byte leaves the FIFO only in the access phase of a data-port read, never in the setup phase.
- R13: A receive event and a transmit event whose interrupts are enabled in the same cycle produce a single one-cycle `irq` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid in the access phase |
| pready | output | 1 | Transfer complete, tied high |
| pslverr | output | 1 | Transfer error, tied low |
| rxValid | input | 1 | Received byte offered |
| rxData | input | 8 | Received byte |
| rxReady | output | 1 | Receive FIFO can take a byte |
| txValid | output | 1 | One-cycle strobe for a byte to transmit |
| txData | output | 8 | Byte to transmit |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Read data is combinational in the APB access phase, so the bench samples `prdata` in that same cycle, before the edge that ends the transfer. `txValid`, `txData` and `irq` come from registers loaded on the access edge or the receive-accept edge. The bench therefore samples them at the falling edge right after that edge, and again one cycle later to confirm they last a single cycle. Status bits, data ready and the FIFO contents change on the same edge. They are checked through later register reads, and `rxReady` is checked at the falling edge after the byte that fills the FIFO.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;

  localparam int BUS_W  = 32;
  localparam int ADDR_W = 8;
  localparam int BYTE_W = 8;

  // register byte addresses
  localparam logic [ADDR_W-1:0] OFF_DATA      = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_DATA_LANE = 8'h03;
  localparam logic [ADDR_W-1:0] OFF_STATUS    = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_CTRL      = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_SCALER    = 8'h0C;

  // status bit positions
  localparam int ST_READY      = 0;
  localparam int ST_SHIFT_IDLE = 1;
  localparam int ST_TXQ_EMPTY  = 2;
  localparam int ST_OVERRUN    = 4;
  localparam int ST_TXQ_FULL   = 9;
  localparam int ST_RXQ_FULL   = 10;

  // control bit positions
  localparam int CT_RX_ON  = 0;
  localparam int CT_TX_ON  = 1;
  localparam int CT_RX_IRQ = 2;
  localparam int CT_TX_IRQ = 3;

  typedef enum logic [1:0] {
    SEL_ZERO   = 2'd0,
    SEL_DATA   = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_CTRL   = 2'd3
  } rd_sel_e;

  // strobes from the decoder to the datapath
  typedef struct packed {
    logic readData;
    logic writeData;
    logic writeCtrl;
  } strobe_t;

endpackage

// File: rtl/uart_reg_decode.sv
module uart_reg_decode
  import uart_reg_pkg::*;
(
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output strobe_t           strobes,
  output rd_sel_e           rdSel
);

  rd_sel_e sel;
  logic    access;

  assign access = psel & penable;

  always_comb begin
    unique case (paddr)
      OFF_DATA, OFF_DATA_LANE: sel = SEL_DATA;
      OFF_STATUS:              sel = SEL_STATUS;
      OFF_CTRL:                sel = SEL_CTRL;
      OFF_SCALER:              sel = SEL_ZERO;
      default:                 sel = SEL_ZERO;
    endcase
  end

  always_comb begin
    strobes.readData  = access & ~pwrite & (sel == SEL_DATA);
    strobes.writeData = access &  pwrite & (sel == SEL_DATA);
    strobes.writeCtrl = access &  pwrite & (sel == SEL_CTRL);
  end

  assign rdSel = sel;

endmodule

// File: rtl/uart_reg_fifo.sv
module uart_reg_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             empty,
  output logic             full,
  output logic [CNT_W-1:0] count
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr, wrNext, rdNext;
  logic             doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(DEPTH));
  assign doPush = push & ~full;
  assign doPop  = pop & ~empty;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wrNext = wrPtr + 1'b1;
      assign rdNext = rdPtr + 1'b1;
    end else begin : g_wrap
      assign wrNext = (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      assign rdNext = (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrNext;
      if (doPop)  rdPtr <= rdNext;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign headData = mem[rdPtr];

endmodule

// File: rtl/uart_reg_datapath.sv
module uart_reg_datapath
  import uart_reg_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  rd_sel_e           rdSel,
  input  logic [BUS_W-1:0]  pwdata,
  output logic [BUS_W-1:0]  prdata,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxData,
  output logic              rxReady,
  output logic              txValid,
  output logic [BYTE_W-1:0] txData,
  output logic              irq
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [BUS_W-1:0]  ctrlReg;
  logic [BUS_W-1:0]  statusWord;
  logic              dataReady;
  logic              rxAccept, txSend, doPop;
  logic [BYTE_W-1:0] headData;
  logic              fifoEmpty, fifoFull;
  logic [CNT_W-1:0]  fifoCount;

  assign rxAccept = rxValid & ~fifoFull & ctrlReg[CT_RX_ON];
  assign txSend   = strobes.writeData & ctrlReg[CT_TX_ON];
  assign doPop    = strobes.readData & ~fifoEmpty;
  assign rxReady  = ~fifoFull;

  uart_reg_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_rxq (
    .clk      (clk),
    .rstN     (rstN),
    .push     (rxAccept),
    .pushData (rxData),
    .pop      (doPop),
    .headData (headData),
    .empty    (fifoEmpty),
    .full     (fifoFull),
    .count    (fifoCount)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      dataReady <= 1'b0;
      txValid   <= 1'b0;
      txData    <= '0;
      irq       <= 1'b0;
    end else begin
      if (strobes.writeCtrl) ctrlReg <= pwdata;
      if (rxAccept)
        dataReady <= 1'b1;
      else if (strobes.readData && fifoCount <= CNT_W'(1))
        dataReady <= 1'b0;
      txValid <= txSend;
      if (txSend) txData <= pwdata[BYTE_W-1:0];
      irq <= (rxAccept & ctrlReg[CT_RX_IRQ]) | (txSend & ctrlReg[CT_TX_IRQ]);
    end
  end

  always_comb begin
    statusWord                = '0;
    statusWord[ST_READY]      = dataReady;
    statusWord[ST_SHIFT_IDLE] = 1'b1;
    statusWord[ST_TXQ_EMPTY]  = 1'b1;
    statusWord[ST_OVERRUN]    = 1'b0;
    statusWord[ST_TXQ_FULL]   = 1'b0;
    statusWord[ST_RXQ_FULL]   = fifoFull;
  end

  always_comb begin
    unique case (rdSel)
      SEL_DATA:   prdata = fifoEmpty ? '0 : {{(BUS_W-BYTE_W){1'b0}}, headData};
      SEL_STATUS: prdata = statusWord;
      SEL_CTRL:   prdata = ctrlReg;
      default:    prdata = '0;
    endcase
  end

endmodule

// File: rtl/uart_reg_front.sv
module uart_reg_front
  import uart_reg_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [7:0]  paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        pready,
  output logic        pslverr,
  input  logic        rxValid,
  input  logic [7:0]  rxData,
  output logic        rxReady,
  output logic        txValid,
  output logic [7:0]  txData,
  output logic        irq
);

  strobe_t strobes;
  rd_sel_e rdSel;

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  uart_reg_decode u_dec (
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .strobes (strobes),
    .rdSel   (rdSel)
  );

  uart_reg_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .rdSel   (rdSel),
    .pwdata  (pwdata),
    .prdata  (prdata),
    .rxValid (rxValid),
    .rxData  (rxData),
    .rxReady (rxReady),
    .txValid (txValid),
    .txData  (txData),
    .irq     (irq)
  );

endmodule

// File: rtl/uart_reg_front_checker.sv
module uart_reg_front_checker #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             psel,
  input logic             penable,
  input logic             pwrite,
  input logic [7:0]       paddr,
  input logic             rxValid,
  input logic             rxReady,
  input logic             txValid,
  input logic             irq,
  input logic [31:0]      ctrlReg,
  input logic             dataReady,
  input logic [CNT_W-1:0] fifoCount
);

  logic isData, wrData, rdData, wrCtrl;
  assign isData = (paddr == 8'h00) || (paddr == 8'h03);
  assign wrData = psel && penable && pwrite && isData;
  assign rdData = psel && penable && !pwrite && isData;
  assign wrCtrl = psel && penable && pwrite && (paddr == 8'h08);

  assert_ctrl_only_by_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ctrlReg) |-> $past(wrCtrl));

  assert_ready_matches_fifo_R8: assert property (@(posedge clk) disable iff (!rstN)
    dataReady == (fifoCount != '0));

  assert_tx_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> $past(wrData && ctrlReg[1]));

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CNT_W'(DEPTH));

  assert_full_blocks_rx_R11: assert property (@(posedge clk) disable iff (!rstN)
    (fifoCount == CNT_W'(DEPTH)) |-> !rxReady);

  assert_pop_in_access_R12: assert property (@(posedge clk) disable iff (!rstN)
    (fifoCount < $past(fifoCount)) |-> $past(rdData));

  assert_irq_source_R13: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past((rxValid && rxReady && ctrlReg[0] && ctrlReg[2]) ||
                  (wrData && ctrlReg[1] && ctrlReg[3])));

endmodule

bind uart_reg_front uart_reg_front_checker #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .psel      (psel),
  .penable   (penable),
  .pwrite    (pwrite),
  .paddr     (paddr),
  .rxValid   (rxValid),
  .rxReady   (rxReady),
  .txValid   (txValid),
  .irq       (irq),
  .ctrlReg   (u_dp.ctrlReg),
  .dataReady (u_dp.dataReady),
  .fifoCount (u_dp.fifoCount)
);

// File: tb/uart_reg_front_bench.sv
module uart_reg_front_bench;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = '0;
  logic        rxReady, txValid;
  logic [7:0]  txData;
  logic        irq;

  int checkCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_reg_front #(.DEPTH(DEPTH)) u_uart_reg_front (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .rxValid(rxValid), .rxData(rxData), .rxReady(rxReady),
    .txValid(txValid), .txData(txData), .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;   // write data, or expected read data
    logic [7:0]  req;
  } vec_t;

  // register-level vectors: R5 reset values, R2 status read-only, R3 control,
  // R4 scaler and unmapped, R8 empty read
  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'h04, 32'h0000_0006, 8'd5},
    '{1'b0, 8'h08, 32'h0000_0000, 8'd5},
    '{1'b1, 8'h08, 32'h1234_5670, 8'd3},
    '{1'b0, 8'h08, 32'h1234_5670, 8'd3},
    '{1'b1, 8'h04, 32'hFFFF_FFFF, 8'd2},
    '{1'b0, 8'h04, 32'h0000_0006, 8'd2},
    '{1'b1, 8'h0C, 32'h0000_00FF, 8'd4},
    '{1'b0, 8'h0C, 32'h0000_0000, 8'd4},
    '{1'b1, 8'h14, 32'hDEAD_BEEF, 8'd4},
    '{1'b0, 8'h14, 32'h0000_0000, 8'd4},
    '{1'b0, 8'h08, 32'h1234_5670, 8'd4},
    '{1'b0, 8'h00, 32'h0000_0000, 8'd8},
    '{1'b1, 8'h08, 32'h0000_0000, 8'd3},
    '{1'b0, 8'h08, 32'h0000_0000, 8'd3}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic apbWrite(input logic [7:0] a, input logic [31:0] d,
                          input bit withRx = 1'b0, input logic [7:0] rb = '0);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    if (withRx) begin rxValid = 1'b1; rxData = rb; end
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; rxValid = 1'b0;
  endtask

  task automatic apbRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #1;
    d = prdata;
    check("R12 pready", {31'b0, pready}, 32'd1);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic pushByte(input logic [7:0] b);
    @(negedge clk);
    rxValid = 1'b1; rxData = b;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic finishRun;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: actual hung expected done");
      finishRun();
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R5 / R12 outputs after reset
    check("R5 txValid", {31'b0, txValid}, 32'd0);
    check("R5 irq", {31'b0, irq}, 32'd0);
    check("R5 rxReady", {31'b0, rxReady}, 32'd1);
    check("R12 pslverr", {31'b0, pslverr}, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].wr) apbWrite(VECS[i].addr, VECS[i].data);
      else begin
        apbRead(VECS[i].addr, rd);
        check($sformatf("R%0d vector %0d", VECS[i].req, i), rd, VECS[i].data);
      end
    end

    // R6: receiver disabled, byte discarded
    pushByte(8'h11);
    check("R6 irq", {31'b0, irq}, 32'd0);
    apbRead(8'h04, rd);
    check("R6 status", rd, 32'h6);
    apbRead(8'h00, rd);
    check("R6 data", rd, 32'h0);

    // R7: accept with receive interrupt
    apbWrite(8'h08, 32'h5);
    pushByte(8'hA1);
    check("R7 irq pulse", {31'b0, irq}, 32'd1);
    @(negedge clk);
    check("R7 irq one cycle", {31'b0, irq}, 32'd0);
    apbRead(8'h04, rd);
    check("R7 status ready", rd, 32'h7);
    pushByte(8'hB2);
    pushByte(8'hC3);

    // R1 lane alias, R8 order and ready clearing
    apbRead(8'h03, rd);
    check("R1 lane alias", rd, 32'hA1);
    apbRead(8'h00, rd);
    check("R8 second", rd, 32'hB2);
    apbRead(8'h04, rd);
    check("R8 still ready", rd, 32'h7);
    apbRead(8'h00, rd);
    check("R8 third", rd, 32'hC3);
    apbRead(8'h04, rd);
    check("R8 ready cleared", rd, 32'h6);
    apbRead(8'h00, rd);
    check("R8 empty read", rd, 32'h0);

    // R12: setup phase alone does not pop
    pushByte(8'h5A);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = 8'h00;
    repeat (3) @(negedge clk);
    psel = 1'b0;
    apbRead(8'h00, rd);
    check("R12 no setup pop", rd, 32'h5A);

    // R11: fill, full blocks further bytes
    apbWrite(8'h08, 32'h1);
    for (int i = 0; i < DEPTH; i++) pushByte(8'h40 + 8'(i));
    check("R11 rxReady low", {31'b0, rxReady}, 32'd0);
    apbRead(8'h04, rd);
    check("R11 status full", rd, 32'h407);
    pushByte(8'hEE);
    for (int i = 0; i < DEPTH; i++) begin
      apbRead(8'h00, rd);
      check("R11 drain order", rd, 32'h40 + i);
    end
    apbRead(8'h00, rd);
    check("R11 extra dropped", rd, 32'h0);
    check("R11 rxReady high", {31'b0, rxReady}, 32'd1);

    // R9: transmitter disabled, then enabled without interrupt
    apbWrite(8'h00, 32'h55);
    check("R9 dropped", {31'b0, txValid}, 32'd0);
    apbWrite(8'h08, 32'h2);
    apbWrite(8'h00, 32'h1234_56AB);
    check("R9 txValid", {31'b0, txValid}, 32'd1);
    check("R9 txData", {24'b0, txData}, 32'hAB);
    check("R10 no irq", {31'b0, irq}, 32'd0);
    @(negedge clk);
    check("R9 one cycle", {31'b0, txValid}, 32'd0);

    // R10: transmit interrupt
    apbWrite(8'h08, 32'hA);
    apbWrite(8'h03, 32'h3C);
    check("R10 irq", {31'b0, irq}, 32'd1);
    check("R10 txData", {24'b0, txData}, 32'h3C);
    @(negedge clk);
    check("R10 irq one cycle", {31'b0, irq}, 32'd0);

    // R13: simultaneous receive and transmit events
    apbWrite(8'h08, 32'hF);
    apbWrite(8'h00, 32'h99, 1'b1, 8'h77);
    check("R13 irq", {31'b0, irq}, 32'd1);
    check("R13 txValid", {31'b0, txValid}, 32'd1);
    @(negedge clk);
    check("R13 single pulse", {31'b0, irq}, 32'd0);
    apbRead(8'h00, rd);
    check("R13 rx stored", rd, 32'h77);

    done = 1'b1;
    finishRun();
  end

endmodule